// File: doc/BRIEF.md
# Event Translation Request Processor

This block resolves an event raised by a device into a physical interrupt number and a target collection. Requests come from one of two places. A write to the translation register names the device through the bus requester ID and the event through the written data. A queued command names both inside its doublewords and is one of three kinds: trigger, clear or discard. The block takes one request at a time. It reads three entries through a single memory port, each read depending on the one before: the device entry, then the translation entry, then the collection entry. It then decides whether the request is valid.

A valid trigger, whether from a register write or a trigger command, ends with a one-cycle result strobe that carries the interrupt ID and collection ID. A valid discard removes the mapping by writing zeros over the translation entry. A valid clear goes through the same walk but neither reports a result nor writes memory. An invalid request is dropped without any result. A memory error stops the walk at once and is reported on the completion strobe. Table bases and the device ID limit are parameters.

Top module: `evt_xlate_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, done, err, res_valid, mem_rd and mem_wr are all low.
- R2: req_kind encodes 0 = register-write trigger, 1 = clear, 2 = discard, 3 = trigger command. For kind 0 the device ID is req_reqid and the event ID is req_data. For kinds 1 to 3 the device ID is req_dw0[63:32] and the event ID is req_dw1[31:0]. For each kind, the fields that belong to the other source are ignored.
- R3: A kind 0 request presented while unit_en is low is ignored. It causes no memory access and no done pulse, and busy stays low.
- R4: Reads use the fixed order device entry, translation low word, translation high word, collection entry. The device entry is a 64-bit read at DEV_BASE + 8·devid. The translation table base is the device entry's bits [ADDR_W-1:8] with the low 8 bits zero. The translation low word is a 64-bit read at that base + 12·event. The high word is a 32-bit read at base + 12·event + 8. The collection entry is a 64-bit read at COLL_BASE + 8·icid.
- R5: A device ID above MAX_DEVID is dropped with no memory access. done pulses in the cycle after acceptance, with err and res_valid low.
- R6: The request is dropped after the device read when device-entry bit 0 is clear, or when the event ID exceeds 2^(size+1), where size is device-entry bits [5:1]. An event ID equal to that limit is accepted.
- R7: A translation entry is valid only when low-word bits 0 and 1 are both set. The interrupt ID is low-word bits [25:2] and the collection ID is high-word bits [15:0]. An invalid entry drops the request with no collection read.
- R8: A collection entry with bit 0 clear drops the request.
- R9: A fully valid kind 0 or kind 3 request ends with res_valid high together with done, and res_intid and res_icid taken from the translation entry.
- R10: A fully valid clear ends with done alone. It raises no res_valid and makes no memory write.
- R11: A fully valid discard writes 64 zero bits at the translation low word and then 32 zero bits at the high word. It raises no res_valid. mem_wdata is zero whenever mem_wr is high.
- R12: An access acknowledged with mem_err ends the request. The next cycle has done and err high, res_valid low, and no further memory access.
- R13: mem_rd and mem_wr are never high together. Once raised, a memory request keeps its kind and address until mem_ack.
- R14: Each accepted request ends with exactly one single-cycle done pulse. busy is high from acceptance until that pulse and low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_en | input | 1 | Enables register-write requests |
| req_valid | input | 1 | Request present (sampled while busy is low) |
| req_kind | input | 2 | Request kind |
| req_reqid | input | 32 | Bus requester ID (device ID for kind 0) |
| req_data | input | 32 | Register write data (event ID for kind 0) |
| req_dw0 | input | 64 | First command doubleword |
| req_dw1 | input | 64 | Second command doubleword |
| busy | output | 1 | A request is in progress |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_wide | output | 1 | 1 = 64-bit access, 0 = 32-bit access |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access failed, valid with mem_ack |
| done | output | 1 | Request finished (one cycle) |
| err | output | 1 | Request finished on a memory error |
| res_valid | output | 1 | Resolved result present |
| res_intid | output | 24 | Resolved interrupt ID |
| res_icid | output | 16 | Resolved collection ID |

## Verification
Some rules must hold in every cycle, and assertions check those. The memory request stays stable until it is acknowledged, reads and writes never overlap, write data is always zero, a result never appears without done or together with an error, an error ends all memory activity, a disabled register write leaves the block idle, and a device ID over the limit is dropped at once. The remaining behaviour can only be shown by running scenarios in the bench. For each request the bench compares the exact sequence of addresses, widths and directions with a model walk of the same tables. This covers the event-limit boundary, the two translation-entry validity bits, invalid collections, a discard followed by a trigger that no longer resolves, and errors injected at each stage of the walk.

// File: rtl/evt_xlate_pkg.sv
package evt_xlate_pkg;

    localparam int DEVID_W = 32;
    localparam int EVID_W  = 32;
    localparam int INTID_W = 24;
    localparam int ICID_W  = 16;

    typedef enum logic [1:0] {
        RK_REGWR   = 2'd0,
        RK_CLEAR   = 2'd1,
        RK_DISCARD = 2'd2,
        RK_TRIGGER = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_TLO,
        ST_THI,
        ST_COLL,
        ST_ZLO,
        ST_ZHI
    } stage_e;

    typedef struct packed {
        req_kind_e            kind;
        logic [DEVID_W-1:0]   devid;
        logic [EVID_W-1:0]    evid;
    } xreq_t;

    // Largest event ID a device entry admits: 2^(size+1)
    function automatic logic [EVID_W:0] event_limit(input logic [4:0] sz);
        return (EVID_W+1)'(1) << ({1'b0, sz} + 6'd1);
    endfunction

    // Both the live bit and the physical-type bit must be set
    function automatic logic xl_live(input logic [1:0] flags);
        return &flags;
    endfunction

    function automatic logic stage_reads(input stage_e s);
        return (s == ST_DEV) || (s == ST_TLO) || (s == ST_THI) || (s == ST_COLL);
    endfunction

    function automatic logic stage_writes(input stage_e s);
        return (s == ST_ZLO) || (s == ST_ZHI);
    endfunction

    function automatic logic stage_wide(input stage_e s);
        return (s == ST_DEV) || (s == ST_TLO) || (s == ST_COLL) || (s == ST_ZLO);
    endfunction

    function automatic logic kind_resolves(input req_kind_e k);
        return (k == RK_REGWR) || (k == RK_TRIGGER);
    endfunction

endpackage

// File: rtl/evt_req_decode.sv
module evt_req_decode
    import evt_xlate_pkg::*;
(
    input  logic        unit_en,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic [31:0] req_reqid,
    input  logic [31:0] req_data,
    input  logic [63:0] req_dw0,
    input  logic [63:0] req_dw1,
    output logic        accept,
    output xreq_t       req
);

    logic unused_fields;
    assign unused_fields = ^{req_dw0[31:0], req_dw1[63:32]};

    always_comb begin
        req.kind = req_kind_e'(req_kind);
        if (req.kind == RK_REGWR) begin
            req.devid = req_reqid;
            req.evid  = req_data;
        end else begin
            req.devid = req_dw0[63:32];
            req.evid  = req_dw1[31:0];
        end
        accept = req_valid && ((req.kind != RK_REGWR) || unit_en);
    end

endmodule

// File: rtl/evt_addr_gen.sv
module evt_addr_gen
    import evt_xlate_pkg::*;
#(
    parameter int               ADDR_W    = 48,
    parameter logic [ADDR_W-1:0] DEV_BASE  = 48'h0000_0001_0000,
    parameter logic [ADDR_W-1:0] COLL_BASE = 48'h0000_0002_0000
) (
    input  stage_e              stage,
    input  logic [DEVID_W-1:0]  devid,
    input  logic [EVID_W-1:0]   evid,
    input  logic [ADDR_W-1:0]   itt_base,
    input  logic [ICID_W-1:0]   icid,
    output logic [ADDR_W-1:0]   addr,
    output logic                wide
);

    logic [ADDR_W-1:0] dev_addr, tr_lo, tr_hi, coll_addr, ev_ext;

    always_comb begin
        ev_ext    = ADDR_W'(evid);
        dev_addr  = DEV_BASE + (ADDR_W'(devid) << 3);
        tr_lo     = itt_base + (ev_ext << 3) + (ev_ext << 2);
        tr_hi     = tr_lo + ADDR_W'(8);
        coll_addr = COLL_BASE + (ADDR_W'(icid) << 3);
        unique case (stage)
            ST_DEV:          addr = dev_addr;
            ST_TLO, ST_ZLO:  addr = tr_lo;
            ST_THI, ST_ZHI:  addr = tr_hi;
            ST_COLL:         addr = coll_addr;
            default:         addr = '0;
        endcase
        wide = stage_wide(stage);
    end

endmodule

// File: rtl/evt_xlate_seq.sv
module evt_xlate_seq
    import evt_xlate_pkg::*;
#(
    parameter int          ADDR_W    = 48,
    parameter logic [31:0] MAX_DEVID = 32'd1023
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  xreq_t               in_req,
    input  logic                mem_ack,
    input  logic                mem_err,
    input  logic [63:0]         mem_rdata,
    output stage_e              stage,
    output logic [DEVID_W-1:0]  cur_devid,
    output logic [EVID_W-1:0]   cur_evid,
    output logic [ADDR_W-1:0]   itt_base,
    output logic [ICID_W-1:0]   cur_icid,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic                res_valid,
    output logic [INTID_W-1:0]  res_intid,
    output logic [ICID_W-1:0]   res_icid
);

    xreq_t       cur;
    logic [63:0] dte_q;
    logic [63:0] lo_q;
    logic [ICID_W-1:0] icid_q;

    logic unused_bits;
    assign unused_bits = ^{dte_q[63:ADDR_W], dte_q[7:0], lo_q[63:26]};

    assign cur_devid = cur.devid;
    assign cur_evid  = cur.evid;
    assign cur_icid  = icid_q;
    assign itt_base  = {dte_q[ADDR_W-1:8], 8'h00};
    assign busy      = (stage != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage     <= ST_IDLE;
            cur       <= '0;
            dte_q     <= '0;
            lo_q      <= '0;
            icid_q    <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
            res_valid <= 1'b0;
            res_intid <= '0;
            res_icid  <= '0;
        end else begin
            done      <= 1'b0;
            err       <= 1'b0;
            res_valid <= 1'b0;
            unique case (stage)
                ST_IDLE: begin
                    if (accept) begin
                        cur <= in_req;
                        if (in_req.devid > MAX_DEVID) done  <= 1'b1;
                        else                          stage <= ST_DEV;
                    end
                end
                ST_DEV: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            done <= 1'b1; err <= 1'b1; stage <= ST_IDLE;
                        end else begin
                            dte_q <= mem_rdata;
                            if (!mem_rdata[0] ||
                                ({1'b0, cur.evid} > event_limit(mem_rdata[5:1]))) begin
                                done <= 1'b1; stage <= ST_IDLE;
                            end else begin
                                stage <= ST_TLO;
                            end
                        end
                    end
                end
                ST_TLO: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            done <= 1'b1; err <= 1'b1; stage <= ST_IDLE;
                        end else begin
                            lo_q  <= mem_rdata;
                            stage <= ST_THI;
                        end
                    end
                end
                ST_THI: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            done <= 1'b1; err <= 1'b1; stage <= ST_IDLE;
                        end else begin
                            icid_q <= mem_rdata[ICID_W-1:0];
                            if (!xl_live(lo_q[1:0])) begin
                                done <= 1'b1; stage <= ST_IDLE;
                            end else begin
                                stage <= ST_COLL;
                            end
                        end
                    end
                end
                ST_COLL: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            done <= 1'b1; err <= 1'b1; stage <= ST_IDLE;
                        end else if (!mem_rdata[0]) begin
                            done <= 1'b1; stage <= ST_IDLE;
                        end else if (cur.kind == RK_DISCARD) begin
                            stage <= ST_ZLO;
                        end else begin
                            done  <= 1'b1;
                            stage <= ST_IDLE;
                            if (kind_resolves(cur.kind)) begin
                                res_valid <= 1'b1;
                                res_intid <= lo_q[25:2];
                                res_icid  <= icid_q;
                            end
                        end
                    end
                end
                ST_ZLO: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            done <= 1'b1; err <= 1'b1; stage <= ST_IDLE;
                        end else begin
                            stage <= ST_ZHI;
                        end
                    end
                end
                ST_ZHI: begin
                    if (mem_ack) begin
                        done  <= 1'b1;
                        err   <= mem_err;
                        stage <= ST_IDLE;
                    end
                end
                default: stage <= ST_IDLE;
            endcase
        end
    end

    AST_LIMIT_DROP: assert property (@(posedge clk) disable iff (rst)
        (stage == ST_IDLE && accept && in_req.devid > MAX_DEVID)
            |=> (stage == ST_IDLE && done && !res_valid && !err)); // R5

    AST_RES_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (done && !err)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R14

endmodule

// File: rtl/evt_xlate_engine.sv
module evt_xlate_engine
    import evt_xlate_pkg::*;
#(
    parameter int               ADDR_W    = 48,
    parameter logic [ADDR_W-1:0] DEV_BASE  = 48'h0000_0001_0000,
    parameter logic [ADDR_W-1:0] COLL_BASE = 48'h0000_0002_0000,
    parameter logic [31:0]      MAX_DEVID = 32'd1023
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              unit_en,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [31:0]       req_reqid,
    input  logic [31:0]       req_data,
    input  logic [63:0]       req_dw0,
    input  logic [63:0]       req_dw1,
    output logic              busy,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_wide,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic [63:0]       mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              done,
    output logic              err,
    output logic              res_valid,
    output logic [23:0]       res_intid,
    output logic [15:0]       res_icid
);

    logic               accept;
    xreq_t              dec_req;
    stage_e             stage;
    logic [DEVID_W-1:0] cur_devid;
    logic [EVID_W-1:0]  cur_evid;
    logic [ADDR_W-1:0]  itt_base;
    logic [ICID_W-1:0]  cur_icid;

    evt_req_decode u_dec (
        .unit_en   (unit_en),
        .req_valid (req_valid && !busy),
        .req_kind  (req_kind),
        .req_reqid (req_reqid),
        .req_data  (req_data),
        .req_dw0   (req_dw0),
        .req_dw1   (req_dw1),
        .accept    (accept),
        .req       (dec_req)
    );

    evt_xlate_seq #(
        .ADDR_W    (ADDR_W),
        .MAX_DEVID (MAX_DEVID)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .in_req    (dec_req),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .mem_rdata (mem_rdata),
        .stage     (stage),
        .cur_devid (cur_devid),
        .cur_evid  (cur_evid),
        .itt_base  (itt_base),
        .cur_icid  (cur_icid),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .res_valid (res_valid),
        .res_intid (res_intid),
        .res_icid  (res_icid)
    );

    evt_addr_gen #(
        .ADDR_W    (ADDR_W),
        .DEV_BASE  (DEV_BASE),
        .COLL_BASE (COLL_BASE)
    ) u_addr (
        .stage    (stage),
        .devid    (cur_devid),
        .evid     (cur_evid),
        .itt_base (itt_base),
        .icid     (cur_icid),
        .addr     (mem_addr),
        .wide     (mem_wide)
    );

    assign mem_rd    = stage_reads(stage);
    assign mem_wr    = stage_writes(stage);
    assign mem_wdata = '0;

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R13

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd || mem_wr) && !mem_ack)
            |=> ($stable(mem_rd) && $stable(mem_wr) && $stable(mem_addr) && $stable(mem_wide))); // R13

    AST_WR_ZERO: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_wdata == 64'd0)); // R11

    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd || mem_wr) && mem_ack && mem_err)
            |=> (!mem_rd && !mem_wr && done && err && !res_valid)); // R12

    AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && req_kind == 2'd0 && !unit_en)
            |=> (!busy && !done && !mem_rd)); // R3

endmodule

// File: tb/tb_evt_xlate_engine.sv
`timescale 1ns/1ps
module tb_evt_xlate_engine;

    localparam int          AW     = 48;
    localparam longint      DEVB   = 64'h1_0000;
    localparam longint      COLLB  = 64'h2_0000;
    localparam longint      MAXDEV = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          unit_en = 1'b0, req_valid = 1'b0;
    logic [1:0]    req_kind = '0;
    logic [31:0]   req_reqid = '0, req_data = '0;
    logic [63:0]   req_dw0 = '0, req_dw1 = '0;
    logic          busy, mem_rd, mem_wr, mem_wide;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata;
    logic [63:0]   mem_rdata = '0;
    logic          mem_ack = 1'b0, mem_err = 1'b0;
    logic          done, err, res_valid;
    logic [23:0]   res_intid;
    logic [15:0]   res_icid;

    evt_xlate_engine #(.ADDR_W(AW), .DEV_BASE(48'h1_0000), .COLL_BASE(48'h2_0000),
                       .MAX_DEVID(32'd6)) dut (
        .clk(clk), .rst(rst), .unit_en(unit_en), .req_valid(req_valid),
        .req_kind(req_kind), .req_reqid(req_reqid), .req_data(req_data),
        .req_dw0(req_dw0), .req_dw1(req_dw1), .busy(busy), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wide(mem_wide), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .done(done), .err(err), .res_valid(res_valid),
        .res_intid(res_intid), .res_icid(res_icid)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // memory model
    logic [63:0] mem [longint];
    bit          err_on = 1'b0;
    longint      err_addr = 0;
    int          wr_cnt = 0;
    longint      act_addr [8];
    bit          act_wide [8];
    bit          act_wr   [8];
    int          act_n = 0;

    function automatic logic [63:0] mrd(input longint a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end else if ((mem_rd || mem_wr) && !mem_ack) begin
            mem_ack <= 1'b1;
            if (act_n < 8) begin
                act_addr[act_n] = longint'(mem_addr);
                act_wide[act_n] = mem_wide;
                act_wr[act_n]   = mem_wr;
            end
            act_n++;
            if (mem_rd) begin
                mem_err   <= err_on && (longint'(mem_addr) == err_addr);
                mem_rdata <= mem_wide ? mrd(longint'(mem_addr))
                                      : {32'h0, mrd(longint'(mem_addr))[31:0]};
            end else begin
                mem_err <= 1'b0;
                mem[longint'(mem_addr)] = mem_wide ? mem_wdata : {32'h0, mem_wdata[31:0]};
                wr_cnt++;
            end
        end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end
    end

    // reference walk
    longint exp_addr [8];
    bit     exp_wide [8];
    bit     exp_wr   [8];
    int     exp_n;
    bit     e_done, e_err, e_res;
    longint e_intid, e_icid;

    task automatic push(input longint a, input bit w, input bit wr);
        exp_addr[exp_n] = a; exp_wide[exp_n] = w; exp_wr[exp_n] = wr; exp_n++;
    endtask

    function automatic bit hit(input longint a);
        return err_on && (a == err_addr);
    endfunction

    task automatic predict(input int kind, input longint dev, input longint ev, input bit en);
        logic [63:0] dte, lo, hi, cte;
        longint lim, ta, ca;
        exp_n = 0; e_done = 0; e_err = 0; e_res = 0; e_intid = 0; e_icid = 0;
        if (kind == 0 && !en) return;
        e_done = 1;
        if (dev > MAXDEV) return;
        push(DEVB + dev*8, 1, 0);
        if (hit(DEVB + dev*8)) begin e_err = 1; return; end
        dte = mrd(DEVB + dev*8);
        if (!dte[0]) return;
        lim = 64'd1 << (dte[5:1] + 1);
        if (ev > lim) return;
        ta = longint'({16'h0, dte[47:8], 8'h00}) + ev*12;
        push(ta, 1, 0);
        if (hit(ta)) begin e_err = 1; return; end
        lo = mrd(ta);
        push(ta + 8, 0, 0);
        if (hit(ta + 8)) begin e_err = 1; return; end
        hi = mrd(ta + 8);
        if (!(lo[0] && lo[1])) return;
        ca = COLLB + longint'(hi[15:0]) * 8;
        push(ca, 1, 0);
        if (hit(ca)) begin e_err = 1; return; end
        cte = mrd(ca);
        if (!cte[0]) return;
        if (kind == 2) begin
            push(ta, 1, 1);
            push(ta + 8, 0, 1);
        end else if (kind == 0 || kind == 3) begin
            e_res = 1; e_intid = longint'(lo[25:2]); e_icid = longint'(hi[15:0]);
        end
    endtask

    task automatic run_req(input int kind, input longint dev, input longint ev,
                           input bit en, input string tag);
        bit got = 0;
        bit g_err = 0, g_res = 0;
        longint g_int = 0, g_icid = 0;
        int w0 = wr_cnt;
        predict(kind, dev, ev, en);
        @(negedge clk);
        act_n     = 0;
        unit_en   = en;
        req_kind  = 2'(kind);
        if (kind == 0) begin
            req_reqid = 32'(dev); req_data = 32'(ev);
            req_dw0 = {$urandom, $urandom}; req_dw1 = {$urandom, $urandom};
        end else begin
            req_reqid = $urandom; req_data = $urandom;
            req_dw0 = {32'(dev), $urandom}; req_dw1 = {$urandom, 32'(ev)};
        end
        req_valid = 1'b1;
        for (int i = 0; i < 40 && !got; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (done) begin
                got = 1; g_err = err; g_res = res_valid;
                g_int = longint'(res_intid); g_icid = longint'(res_icid);
            end
        end
        chk(got == e_done, {tag, " R14 done"}, longint'(got), longint'(e_done));
        if (got) begin
            @(negedge clk);
            chk(!done && !busy, {tag, " R14 single pulse"}, longint'({done, busy}), 0);
            chk(g_err == e_err, {tag, " R12 err"}, longint'(g_err), longint'(e_err));
            chk(g_res == e_res, {tag, " R9 res_valid"}, longint'(g_res), longint'(e_res));
            if (e_res) begin
                chk(g_int == e_intid, {tag, " R7 intid"}, g_int, e_intid);
                chk(g_icid == e_icid, {tag, " R7 icid"}, g_icid, e_icid);
            end
        end
        chk(act_n == exp_n, {tag, " R4 access count"}, longint'(act_n), longint'(exp_n));
        for (int i = 0; i < exp_n && i < act_n && i < 8; i++) begin
            chk(act_addr[i] == exp_addr[i] && act_wide[i] == exp_wide[i] && act_wr[i] == exp_wr[i],
                {tag, " R4 access"}, act_addr[i], exp_addr[i]);
        end
        if (kind != 2) chk(wr_cnt == w0, {tag, " R10 no write"}, longint'(wr_cnt - w0), 0);
    endtask

    // directed table helpers
    task automatic set_dev(input longint d, input bit v, input int sz, input longint itt);
        mem[DEVB + d*8] = {16'hA5A5, 48'h0} | (itt & 64'h0000_FFFF_FFFF_FF00)
                          | (64'(sz) << 1) | 64'(v);
    endtask

    task automatic set_xl(input longint itt, input longint ev, input bit v, input bit t,
                          input longint intid, input longint icid);
        mem[itt + ev*12]     = {38'h2A_DEAD_BEEF >> 0, 26'h0} | (64'(intid & 24'hFFFFFF) << 2)
                               | (64'(t) << 1) | 64'(v);
        mem[itt + ev*12 + 8] = {32'h0, 16'hC3C3, 16'(icid)};
    endtask

    task automatic set_coll(input longint c, input bit v);
        mem[COLLB + c*8] = {32'h1234_5678, 31'h0, v};
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL R14 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !res_valid && !err && !mem_rd && !mem_wr, "R1 in reset",
            longint'({busy, done, res_valid, err, mem_rd, mem_wr}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !res_valid && !err && !mem_rd && !mem_wr, "R1 after reset",
            longint'({busy, done, res_valid, err, mem_rd, mem_wr}), 0);

        // random tables
        for (int d = 0; d < 8; d++) begin
            set_dev(d, d != 3, d % 4, 64'h10_0000 + d * 64'h1000);
            for (int e = 0; e < 18; e++)
                set_xl(64'h10_0000 + d * 64'h1000, e, ($urandom % 8) != 0, ($urandom % 8) != 0,
                       $urandom, $urandom % 10);
        end
        for (int c = 0; c < 8; c++) set_coll(c, c != 5);

        // constrained random phase with error injection
        for (int n = 0; n < 300; n++) begin
            int     k  = $urandom % 4;
            longint dv = $urandom % 9;
            longint ev = $urandom % 18;
            bit     en = ($urandom % 6) != 0;
            predict(k, dv, ev, en);
            if (($urandom % 6) == 0 && exp_n > 0) begin
                int j = $urandom % exp_n;
                if (!exp_wr[j]) begin err_on = 1; err_addr = exp_addr[j]; end
            end
            run_req(k, dv, ev, en, "RAND R2");
            err_on = 0;
        end

        // directed corners on device 0
        set_dev(0, 1, 2, 64'h30_0000);                 // limit 8
        set_xl(64'h30_0000, 1, 1, 1, 24'h1234, 2);
        set_xl(64'h30_0000, 2, 1, 0, 24'h55, 2);        // type bit clear
        set_xl(64'h30_0000, 3, 1, 1, 24'h77, 5);        // collection 5 invalid
        set_xl(64'h30_0000, 8, 1, 1, 24'hABCDEF, 7);
        set_xl(64'h30_0000, 9, 1, 1, 24'h99, 1);
        set_coll(2, 1); set_coll(5, 0); set_coll(7, 1); set_coll(1, 1);

        run_req(3, 0, 1, 1, "R9 trigger cmd");
        run_req(0, 0, 8, 1, "R2 R6 regwr at limit");
        run_req(0, 0, 8, 0, "R3 disabled regwr");
        chk(!busy, "R3 idle", longint'(busy), 0);
        run_req(3, 0, 9, 1, "R6 over event limit");
        run_req(3, 3, 0, 1, "R6 invalid device");
        run_req(3, 7, 0, 1, "R5 device over limit");
        run_req(0, 7, 0, 1, "R5 regwr device over limit");
        run_req(3, 0, 2, 1, "R7 type bit clear");
        run_req(3, 0, 3, 1, "R8 invalid collection");
        begin
            int w0 = wr_cnt;
            run_req(1, 0, 1, 1, "R10 clear");
            chk(wr_cnt == w0, "R10 clear writes", longint'(wr_cnt - w0), 0);
        end
        run_req(2, 0, 1, 0, "R11 discard");
        chk(mrd(64'h30_0000 + 12) == 0, "R11 low word zero", mrd(64'h30_0000 + 12), 0);
        chk(mrd(64'h30_0000 + 20) == 0, "R11 high word zero", mrd(64'h30_0000 + 20), 0);
        run_req(3, 0, 1, 1, "R11 trigger after discard");
        err_on = 1; err_addr = DEVB;
        run_req(3, 0, 8, 1, "R12 error at device read");
        err_addr = COLLB + 7 * 8;
        run_req(0, 0, 8, 1, "R12 error at collection read");
        err_on = 0;
        run_req(0, 0, 8, 1, "R9 R13 recovery");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule